// File: doc/BRIEF.md
# Radio Front-End Control Sequencer

This block sits between a WLAN baseband and an external radio. It drives the radio's digital control lines: a two-bit power-state code, a complementary transmit/receive switch pair, the PA power enable, a complementary antenna-select pair and an AGC start/done handshake. The baseband requests radio modes, transmit start and end events, antenna steps and AGC cycles through single-cycle strobes. The block orders these requests so that the PA and the switch never disagree with the radio state.

A serial programming port shifts 24-bit words into the radio over a clock, data and active-low enable triple. Words enter through a valid/ready stream. A word is taken on a cycle where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` stays low while a word is being shifted, which applies back-pressure to the source. The source holds `cfg_data` steady with `cfg_valid` high until the word is taken.

Top module: `rf_ctrl_seq`

## Requirements
- R1: `rf_state` is 2'b00 for power-down, 2'b01 for idle (PLL and serial port alive, no transmit or receive), 2'b11 for receive and 2'b10 for transmit. Reset gives power-down. A `mode_stb` with PA off loads `mode_req` into `rf_state` one cycle later.
- R2: `trsw_p` is 1 exactly when `rf_state` is transmit (2'b10). `trsw_n` is always its inverse.
- R3: `pa_en` rises one cycle after a `tx_start` strobe that arrives while `rf_state` is transmit and `pa_en` is low. A `tx_start` in any other mode is ignored.
- R4: `pa_en` falls one cycle after a `tx_done` strobe. A `mode_stb` that arrives while `pa_en` is high is held, and it takes effect on `rf_state` one cycle after `pa_en` falls.
- R5: `ant_p` toggles one cycle after an `ant_step` strobe that arrives while `rf_state` is receive. Outside receive, the strobe is ignored. `ant_n` is always `~ant_p`, and reset gives `ant_p` = 0.
- R6: `agc_go` raises `agc_rst` one cycle later and clears `agc_timeout`. While `agc_rst` is high, `agc_done` high drops `agc_rst` on the next cycle.
- R7: If `agc_done` does not come, `agc_rst` stays high for `agc_limit`+1 cycles, then drops low, and `agc_timeout` becomes 1.
- R8: An accepted word is shifted MSB first. Each bit is presented on `ser_data` while `ser_le_n` is low, and the radio samples it on the rising edge of `ser_clk`. There are exactly 24 rising edges per word. `ser_clk` has `cfg_half` cycles low and then `cfg_half` cycles high per bit (0 is treated as 1), so `ser_le_n` is low for 48*`cfg_half` cycles.
- R9: `cfg_ready` is low exactly while `ser_le_n` is low, and it returns high in the same cycle as `ser_le_n`. While `ser_le_n` is high, `ser_clk` and `ser_data` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_stb | input | 1 | Mode request strobe |
| mode_req | input | 2 | Requested mode code |
| tx_start | input | 1 | Transmission start strobe |
| tx_done | input | 1 | Last transmit sample done strobe |
| rf_state | output | 2 | Radio power-state code |
| trsw_p | output | 1 | T/R switch, 1 = transmit |
| trsw_n | output | 1 | T/R switch complement |
| pa_en | output | 1 | PA power enable |
| ant_step | input | 1 | Move to the other antenna |
| ant_p | output | 1 | Antenna select |
| ant_n | output | 1 | Antenna select complement |
| agc_go | input | 1 | AGC cycle request strobe |
| agc_limit | input | 16 | AGC timeout in cycles |
| agc_done | input | 1 | AGC completion from radio |
| agc_rst | output | 1 | AGC reset/start line to radio |
| agc_timeout | output | 1 | Last AGC cycle timed out |
| cfg_data | input | 24 | Word to program |
| cfg_valid | input | 1 | Word valid |
| cfg_ready | output | 1 | Port can take a word |
| cfg_half | input | 8 | Serial clock half period in cycles |
| ser_clk | output | 1 | Serial shift clock |
| ser_data | output | 1 | Serial data |
| ser_le_n | output | 1 | Serial enable, active low |

## Verification
A wrong mode or pending-request state shows on the next cycle as a mismatch between `rf_state`, `trsw_p` and `pa_en`. This happens most clearly when a deferred request lands one cycle early or late around the fall of the PA. A stuck or miscounted AGC timer shows as an `agc_rst` pulse of the wrong length, at the latest after `agc_limit`+1 cycles. A slip in the serial bit or phase counter shows within one word as a wrong captured value, a rising-edge count other than 24, or an enable window of the wrong length.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
  localparam logic [1:0] MODE_PD   = 2'b00;
  localparam logic [1:0] MODE_IDLE = 2'b01;
  localparam logic [1:0] MODE_TX   = 2'b10;
  localparam logic [1:0] MODE_RX   = 2'b11;

  typedef enum logic {AGC_IDLE = 1'b0, AGC_WAIT = 1'b1} agc_st_e;
endpackage

// File: rtl/rfseq_mode.sv
module rfseq_mode
  import rfseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_stb,
  input  logic [1:0] mode_req,
  input  logic       tx_start,
  input  logic       tx_done,
  output logic [1:0] cur_mode,
  output logic       pa_on
);
  logic       pend_v;
  logic [1:0] pend_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= MODE_PD;
      pa_on    <= 1'b0;
      pend_v   <= 1'b0;
      pend_m   <= MODE_PD;
    end else if (pa_on) begin
      if (tx_done) pa_on <= 1'b0;
      if (mode_stb) begin
        pend_v <= 1'b1;
        pend_m <= mode_req;
      end
    end else if (pend_v) begin
      cur_mode <= pend_m;
      pend_v   <= 1'b0;
    end else begin
      if (mode_stb) cur_mode <= mode_req;
      if (tx_start && cur_mode == MODE_TX) pa_on <= 1'b1;
    end
  end
endmodule

// File: rtl/rfseq_agc.sv
module rfseq_agc
  import rfseq_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [TMO_W-1:0] limit,
  input  logic             done,
  output logic             rst_out,
  output logic             tmo
);
  agc_st_e          st;
  logic [TMO_W-1:0] cnt;

  assign rst_out = (st == AGC_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= AGC_IDLE;
      cnt <= '0;
      tmo <= 1'b0;
    end else if (st == AGC_IDLE) begin
      if (go) begin
        st  <= AGC_WAIT;
        cnt <= '0;
        tmo <= 1'b0;
      end
    end else begin
      if (done) begin
        st <= AGC_IDLE;
      end else if (cnt == limit) begin
        st  <= AGC_IDLE;
        tmo <= 1'b1;
      end else begin
        cnt <= cnt + TMO_W'(1);
      end
    end
  end
endmodule

// File: rtl/rfseq_ant.sv
module rfseq_ant (
  input  logic clk,
  input  logic rst_n,
  input  logic in_rx,
  input  logic step,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)            sel <= 1'b0;
    else if (step && in_rx) sel <= ~sel;
  end
endmodule

// File: rtl/rfseq_3wire.sv
module rfseq_3wire #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DIV_W-1:0]  half,
  output logic              sclk,
  output logic              sdata,
  output logic              le_n
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  half_q;
  logic [BIT_W-1:0]  bitn;

  assign in_ready = le_n;
  assign sdata    = sr[WORD_W-1] & ~le_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_n   <= 1'b1;
      sclk   <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
      half_q <= DIV_W'(1);
      bitn   <= '0;
    end else if (le_n) begin
      if (in_valid) begin
        sr     <= in_data;
        le_n   <= 1'b0;
        sclk   <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
        half_q <= (half == '0) ? DIV_W'(1) : half;
      end
    end else if (cnt == half_q - DIV_W'(1)) begin
      cnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (bitn == LAST) begin
          le_n <= 1'b1;
        end else begin
          bitn <= bitn + BIT_W'(1);
          sr   <= {sr[WORD_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/rf_ctrl_seq.sv
module rf_ctrl_seq
  import rfseq_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_stb,
  input  logic [1:0]        mode_req,
  input  logic              tx_start,
  input  logic              tx_done,
  output logic [1:0]        rf_state,
  output logic              trsw_p,
  output logic              trsw_n,
  output logic              pa_en,
  input  logic              ant_step,
  output logic              ant_p,
  output logic              ant_n,
  input  logic              agc_go,
  input  logic [TMO_W-1:0]  agc_limit,
  input  logic              agc_done,
  output logic              agc_rst,
  output logic              agc_timeout,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [DIV_W-1:0]  cfg_half,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le_n
);
  logic [1:0] mode_q;
  logic       pa_q;
  logic       ant_q;

  rfseq_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_stb(mode_stb), .mode_req(mode_req),
    .tx_start(tx_start), .tx_done(tx_done), .cur_mode(mode_q), .pa_on(pa_q)
  );

  rfseq_ant u_ant (
    .clk(clk), .rst_n(rst_n), .in_rx(mode_q == MODE_RX),
    .step(ant_step), .sel(ant_q)
  );

  rfseq_agc #(.TMO_W(TMO_W)) u_agc (
    .clk(clk), .rst_n(rst_n), .go(agc_go), .limit(agc_limit),
    .done(agc_done), .rst_out(agc_rst), .tmo(agc_timeout)
  );

  rfseq_3wire #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .in_data(cfg_data), .in_valid(cfg_valid),
    .in_ready(cfg_ready), .half(cfg_half), .sclk(ser_clk),
    .sdata(ser_data), .le_n(ser_le_n)
  );

  assign rf_state = mode_q;
  assign pa_en    = pa_q;
  assign trsw_p   = (mode_q == MODE_TX);
  assign trsw_n   = ~trsw_p;
  assign ant_p    = ant_q;
  assign ant_n    = ~ant_q;
endmodule

// File: rtl/rf_ctrl_seq_chk.sv
module rf_ctrl_seq_chk #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_stb,
  input logic [1:0]        mode_req,
  input logic              tx_start,
  input logic              tx_done,
  input logic [1:0]        rf_state,
  input logic              trsw_p,
  input logic              trsw_n,
  input logic              pa_en,
  input logic              ant_step,
  input logic              ant_p,
  input logic              ant_n,
  input logic              agc_go,
  input logic [TMO_W-1:0]  agc_limit,
  input logic              agc_done,
  input logic              agc_rst,
  input logic              agc_timeout,
  input logic [WORD_W-1:0] cfg_data,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic [DIV_W-1:0]  cfg_half,
  input logic              ser_clk,
  input logic              ser_data,
  input logic              ser_le_n
);
  a_r2_switch_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    trsw_p == (rf_state == 2'b10) && trsw_n != trsw_p);

  a_r3_pa_only_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> rf_state == 2'b10);

  a_r4_state_holds_at_pa_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pa_en) |-> rf_state == 2'b10);

  a_r5_ant_moves_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ant_p) |-> $past(rf_state) == 2'b11);

  a_r6_agc_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    agc_rst && agc_done |=> !agc_rst);

  a_r9_idle_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le_n |-> !ser_clk && !ser_data);

  a_r9_ready_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le_n) |-> cfg_ready);
endmodule

bind rf_ctrl_seq rf_ctrl_seq_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/rf_ctrl_seq_test.sv
module rf_ctrl_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_stb = 0, tx_start = 0, tx_done = 0, ant_step = 0, agc_go = 0, agc_done = 0, cfg_valid = 0;
  logic [1:0] mode_req = 0;
  logic [15:0] agc_limit = 16'd5;
  logic [23:0] cfg_data = 0;
  logic [7:0] cfg_half = 8'd2;
  logic [1:0] rf_state;
  logic trsw_p, trsw_n, pa_en, ant_p, ant_n, agc_rst, agc_timeout, cfg_ready, ser_clk, ser_data, ser_le_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rf_ctrl_seq uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {stb, mode[1:0], tx_start, tx_done, exp_state[1:0], exp_pa}
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 2'b01, 1'b0, 1'b0, 2'b01, 1'b0},
    {1'b1, 2'b11, 1'b0, 1'b0, 2'b11, 1'b0},
    {1'b0, 2'b00, 1'b1, 1'b0, 2'b11, 1'b0},
    {1'b1, 2'b10, 1'b0, 1'b0, 2'b10, 1'b0},
    {1'b0, 2'b00, 1'b1, 1'b0, 2'b10, 1'b1},
    {1'b1, 2'b11, 1'b0, 1'b0, 2'b10, 1'b1},
    {1'b0, 2'b00, 1'b0, 1'b1, 2'b10, 1'b0},
    {1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 1'b0},
    {1'b1, 2'b10, 1'b0, 1'b0, 2'b10, 1'b0},
    {1'b0, 2'b00, 1'b1, 1'b0, 2'b10, 1'b1},
    {1'b0, 2'b00, 1'b0, 1'b1, 2'b10, 1'b0},
    {1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0},
    {1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b1, 2'b10, 1'b1, 1'b0, 2'b10, 1'b0}
  };

  logic [23:0] cap;
  int rises;
  always @(posedge ser_clk) if (!ser_le_n) begin
    cap <= {cap[22:0], ser_data};
    rises <= rises + 1;
  end

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_stb = 1; mode_req = m;
    @(negedge clk); mode_stb = 0;
  endtask

  task automatic send_word(input logic [23:0] w, input logic [7:0] h, input int exp_len);
    int n;
    cap = '0; rises = 0;
    @(negedge clk); cfg_data = w; cfg_half = h; cfg_valid = 1;
    @(negedge clk); cfg_valid = 0;
    check("R9 ready low while shifting", cfg_ready, 0);
    n = 0;
    while (!ser_le_n && n < 10000) begin n++; @(negedge clk); end
    check("R8 enable window length", n, exp_len);
    check("R9 ready back with enable", cfg_ready, 1);
    check("R8 rising edge count", rises, 24);
    check("R8 captured word", int'(cap), int'(w));
    check("R9 clock idle low", ser_clk, 0);
    check("R9 data idle low", ser_data, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R1 reset state", rf_state, 0);
    check("R3 reset pa", pa_en, 0);
    check("R2 reset trsw_n", trsw_n, 1);
    check("R5 reset ant_p", ant_p, 0);
    check("R6 reset agc_rst", agc_rst, 0);
    check("R9 reset ready", cfg_ready, 1);
    check("R9 reset le_n", ser_le_n, 1);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      mode_stb = VEC[i][7]; mode_req = VEC[i][6:5];
      tx_start = VEC[i][4]; tx_done = VEC[i][3];
      @(negedge clk);
      mode_stb = 0; tx_start = 0; tx_done = 0;
      check($sformatf("R1/R4 state row %0d", i), rf_state, int'(VEC[i][2:1]));
      check($sformatf("R3/R4 pa row %0d", i), pa_en, int'(VEC[i][0]));
      check($sformatf("R2 trsw_p row %0d", i), trsw_p, int'(VEC[i][2:1] == 2'b10));
      check($sformatf("R2 trsw_n row %0d", i), trsw_n, int'(VEC[i][2:1] != 2'b10));
    end

    // antenna R5: ignored in transmit (state is TX now)
    @(negedge clk); ant_step = 1;
    @(negedge clk); ant_step = 0;
    check("R5 step ignored outside rx", ant_p, 0);
    set_mode(2'b11);
    @(negedge clk); ant_step = 1;
    @(negedge clk); ant_step = 0;
    check("R5 toggle in rx", ant_p, 1);
    check("R5 complement", ant_n, 0);
    ant_step = 1;
    @(negedge clk); ant_step = 0;
    check("R5 toggle back", ant_p, 0);

    // AGC done path R6
    agc_limit = 16'd20;
    agc_go = 1;
    @(negedge clk); agc_go = 0;
    check("R6 agc_rst rises", agc_rst, 1);
    repeat (3) @(negedge clk);
    check("R6 agc_rst held", agc_rst, 1);
    agc_done = 1;
    @(negedge clk); agc_done = 0;
    check("R6 agc_rst drops after done", agc_rst, 0);
    check("R6 no timeout", agc_timeout, 0);

    // AGC timeout R7
    agc_limit = 16'd5;
    agc_go = 1;
    @(negedge clk); agc_go = 0;
    n = 0;
    while (agc_rst && n < 1000) begin n++; @(negedge clk); end
    check("R7 agc_rst high cycles", n, 6);
    check("R7 timeout flag", agc_timeout, 1);
    agc_go = 1;
    @(negedge clk); agc_go = 0;
    check("R6 go clears timeout", agc_timeout, 0);
    agc_done = 1;
    @(negedge clk); agc_done = 0;

    // serial port R8 R9
    send_word(24'hA5C3_1E, 8'd2, 96);
    send_word(24'h80_0001, 8'd0, 48);
    send_word(24'h3C_96F0, 8'd3, 144);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule